// File: doc/BRIEF.md
# Linear Page Table Walker

This block turns a virtual address into a physical address by reading one entry of a flat, single-level page table held in memory. A requester presents a virtual address. The walker splits it into a 4 KB page offset and a virtual page number. It adds eight times the page number to a table base address held in a local register, then fetches that 64-bit entry through a request/acknowledge read port. When the entry is marked valid, the walker joins the frame number from the entry with the untouched offset and reports the result. It also presents the page-number-to-frame pair on a fill port, so a translation cache can store it. When the entry is invalid, it raises a fault pulse instead.

The walk is a fixed sequence of five named states. IDLE waits for a request (IDLE→INDEX on an accepted request). INDEX registers the entry address (INDEX→FETCH always). FETCH drives the read request and waits for the acknowledge (FETCH→FETCH while no acknowledge, FETCH→BUILD on acknowledge). BUILD registers the valid flag, the frame and the physical address (BUILD→REPORT always). REPORT pulses either done or fault for one cycle (REPORT→IDLE always). Only one walk runs at a time. The base register accepts writes only in IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, done, fault, fill_valid and mem_rd_req are all low, and the walker is in IDLE.
- R2: A req_valid seen in IDLE is accepted, and busy is high from the next cycle. busy stays high through the cycle in which done or fault pulses, and is low in the following cycle.
- R3: Two cycles after acceptance, mem_rd_req rises with mem_rd_addr = base + (VA[VA_W-1:12] × 8), modulo 2^MEM_AW. The request and the address stay unchanged until the cycle in which mem_rd_ack is high.
- R4: Entry bit 0 is the valid flag and entry bits [12 +: PA_W-12] hold the frame number. When the flag is set, done is high for exactly one cycle, two cycles after the acknowledge cycle. pa_out then equals {frame, VA[11:0]}.
- R5: When entry bit 0 is clear, fault pulses for one cycle in the slot where done would have pulsed. done and fill_valid stay low.
- R6: fill_valid is high exactly when done is high. fill_vpn then equals VA[VA_W-1:12] and fill_pfn equals the frame number.
- R7: A req_valid that arrives while busy is high is dropped. No second walk and no further read follow the current walk.
- R8: A base write while busy is low updates the base register, and the new value is used for the next walk. A base write while busy is high is discarded.
- R9: done and fault are never high together, and each walk issues exactly one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | MEM_AW | New table base address |
| req_valid | input | 1 | Translation request |
| req_va | input | VA_W | Virtual address to translate |
| busy | output | 1 | Walk in progress; new requests are ignored |
| mem_rd_req | output | 1 | Memory read request for the table entry |
| mem_rd_addr | output | MEM_AW | Byte address of the table entry |
| mem_rd_ack | input | 1 | Read data is valid this cycle |
| mem_rd_data | input | 64 | Table entry returned by memory |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: entry invalid |
| pa_out | output | PA_W | Physical address, valid with done |
| fill_valid | output | 1 | Translation cache fill strobe |
| fill_vpn | output | VA_W-12 | Virtual page number to fill |
| fill_pfn | output | PA_W-12 | Frame number to fill |

## Verification
The walk is tried with an offset-only address in page one and with a mid-range address whose entry carries attribute bits around the frame field. This tells whether the offset is kept and whether the frame is sliced at the right position. The highest page number is also used, which shows whether the scaled index is added at full width. The acknowledge delay is varied from zero to several cycles, which separates a request that is held correctly from one that drops or moves early. An invalid entry shows that fault replaces done. A walk that has a second request and a base write pushed into its wait, followed by a clean walk, shows whether the guards while busy hold or leak.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int PW_OFF_W = 12;
    localparam int PW_PTE_W = 64;
    localparam int PW_PTE_SH = 3;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_INDEX,
        WS_FETCH,
        WS_BUILD,
        WS_REPORT
    } walk_state_t;
endpackage

// File: rtl/pw_index.sv
module pw_index #(
    parameter int VA_W   = 32,
    parameter int MEM_AW = 40
) (
    input  logic [MEM_AW-1:0]             base,
    input  logic [VA_W-1:0]               va,
    output logic [VA_W-pw_pkg::PW_OFF_W-1:0] vpn,
    output logic [MEM_AW-1:0]             pte_addr
);
    import pw_pkg::*;
    localparam int VPN_W = VA_W - PW_OFF_W;
    localparam int IDX_W = VPN_W + PW_PTE_SH;

    logic [IDX_W-1:0] byte_index;

    always_comb begin
        vpn        = va[VA_W-1:PW_OFF_W];
        byte_index = {vpn, {PW_PTE_SH{1'b0}}};
        pte_addr   = base + MEM_AW'(byte_index);
    end
endmodule

// File: rtl/pw_decode.sv
module pw_decode #(
    parameter int PA_W = 40
) (
    input  logic [pw_pkg::PW_PTE_W-1:0]        pte,
    input  logic [pw_pkg::PW_OFF_W-1:0]        offset,
    output logic                               entry_ok,
    output logic [PA_W-pw_pkg::PW_OFF_W-1:0]   pfn,
    output logic [PA_W-1:0]                    pa
);
    import pw_pkg::*;
    localparam int PFN_W = PA_W - PW_OFF_W;

    logic unused_attr;

    always_comb begin
        entry_ok    = pte[0];
        pfn         = pte[PW_OFF_W +: PFN_W];
        pa          = {pfn, offset};
        unused_attr = ^{pte[PW_PTE_W-1:PW_OFF_W+PFN_W], pte[PW_OFF_W-1:1]};
    end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic mem_rd_ack,
    input  logic entry_ok,
    output logic accept,
    output logic ld_addr,
    output logic ld_entry,
    output logic ld_result,
    output logic busy,
    output logic mem_rd_req,
    output logic done,
    output logic fault
);
    import pw_pkg::*;

    walk_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE:   if (req_valid)  state_nx = WS_INDEX;
            WS_INDEX:                  state_nx = WS_FETCH;
            WS_FETCH:  if (mem_rd_ack) state_nx = WS_BUILD;
            WS_BUILD:                  state_nx = WS_REPORT;
            WS_REPORT:                 state_nx = WS_IDLE;
            default:                   state_nx = WS_IDLE;
        endcase
    end

    always_comb begin
        accept     = 1'b0;
        ld_addr    = 1'b0;
        ld_entry   = 1'b0;
        ld_result  = 1'b0;
        busy       = 1'b1;
        mem_rd_req = 1'b0;
        done       = 1'b0;
        fault      = 1'b0;
        unique case (state)
            WS_IDLE: begin
                busy   = 1'b0;
                accept = req_valid;
            end
            WS_INDEX:  ld_addr = 1'b1;
            WS_FETCH: begin
                mem_rd_req = 1'b1;
                ld_entry   = mem_rd_ack;
            end
            WS_BUILD:  ld_result = 1'b1;
            WS_REPORT: begin
                done  = entry_ok;
                fault = !entry_ok;
            end
            default:   busy = 1'b0;
        endcase
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R2
    release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !busy);

    // R9
    done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> mem_rd_req);

    // R9
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack) |=> !mem_rd_req);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int VA_W   = 32,
    parameter int PA_W   = 40,
    parameter int MEM_AW = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    base_wr_en,
    input  logic [MEM_AW-1:0]       base_wr_data,
    input  logic                    req_valid,
    input  logic [VA_W-1:0]         req_va,
    output logic                    busy,
    output logic                    mem_rd_req,
    output logic [MEM_AW-1:0]       mem_rd_addr,
    input  logic                    mem_rd_ack,
    input  logic [63:0]             mem_rd_data,
    output logic                    done,
    output logic                    fault,
    output logic [PA_W-1:0]         pa_out,
    output logic                    fill_valid,
    output logic [VA_W-13:0]        fill_vpn,
    output logic [PA_W-13:0]        fill_pfn
);
    import pw_pkg::*;
    localparam int VPN_W = VA_W - PW_OFF_W;
    localparam int PFN_W = PA_W - PW_OFF_W;

    logic                accept, ld_addr, ld_entry, ld_result;
    logic [MEM_AW-1:0]   base_q, pte_addr_d, pte_addr_q;
    logic [VA_W-1:0]     va_q;
    logic [VPN_W-1:0]    vpn_d;
    logic [PW_PTE_W-1:0] pte_q;
    logic                ok_d, ok_q;
    logic [PFN_W-1:0]    pfn_d, pfn_q;
    logic [PA_W-1:0]     pa_d, pa_q;

    pw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .mem_rd_ack (mem_rd_ack),
        .entry_ok   (ok_q),
        .accept     (accept),
        .ld_addr    (ld_addr),
        .ld_entry   (ld_entry),
        .ld_result  (ld_result),
        .busy       (busy),
        .mem_rd_req (mem_rd_req),
        .done       (done),
        .fault      (fault)
    );

    pw_index #(.VA_W(VA_W), .MEM_AW(MEM_AW)) u_index (
        .base     (base_q),
        .va       (va_q),
        .vpn      (vpn_d),
        .pte_addr (pte_addr_d)
    );

    pw_decode #(.PA_W(PA_W)) u_decode (
        .pte      (pte_q),
        .offset   (va_q[PW_OFF_W-1:0]),
        .entry_ok (ok_d),
        .pfn      (pfn_d),
        .pa       (pa_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            va_q       <= '0;
            pte_addr_q <= '0;
            pte_q      <= '0;
            ok_q       <= 1'b0;
            pfn_q      <= '0;
            pa_q       <= '0;
        end else begin
            if (base_wr_en && !busy) base_q <= base_wr_data;
            if (accept)    va_q       <= req_va;
            if (ld_addr)   pte_addr_q <= pte_addr_d;
            if (ld_entry)  pte_q      <= mem_rd_data;
            if (ld_result) begin
                ok_q  <= ok_d;
                pfn_q <= pfn_d;
                pa_q  <= pa_d;
            end
        end
    end

    always_comb begin
        mem_rd_addr = pte_addr_q;
        pa_out      = pa_q;
        fill_valid  = done;
        fill_vpn    = vpn_d;
        fill_pfn    = pfn_q;
    end

    // R8
    base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base_q));

    // R3
    rd_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> $stable(mem_rd_addr));

    // R7
    va_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(va_q));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam int VA_W = 32, PA_W = 40, MEM_AW = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic base_wr_en = 1'b0, req_valid = 1'b0, mem_rd_ack = 1'b0;
    logic [MEM_AW-1:0] base_wr_data = '0;
    logic [VA_W-1:0] req_va = '0;
    logic [63:0] mem_rd_data = '0;
    logic busy, mem_rd_req, done, fault, fill_valid;
    logic [MEM_AW-1:0] mem_rd_addr;
    logic [PA_W-1:0] pa_out;
    logic [VA_W-13:0] fill_vpn;
    logic [PA_W-13:0] fill_pfn;

    int nvec = 0, nmis = 0;
    logic [MEM_AW-1:0] base_model = '0;

    always #10 clk = ~clk;

    pt_walker #(.VA_W(VA_W), .PA_W(PA_W), .MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_va(req_va), .busy(busy), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .done(done), .fault(fault), .pa_out(pa_out), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", 64'(busy), 0);
        check("R1 done", 64'(done), 0);
        check("R1 fault", 64'(fault), 0);
        check("R1 fill_valid", 64'(fill_valid), 0);
        check("R1 mem_rd_req", 64'(mem_rd_req), 0);
    endtask

    task automatic t_set_base(input logic [MEM_AW-1:0] b);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
        base_model = b;
    endtask

    task automatic t_walk(input logic [VA_W-1:0] va, input logic [63:0] pte,
                          input int delay, input bit intrude);
        logic [MEM_AW-1:0] exp_addr;
        logic [PA_W-13:0]  exp_pfn;
        logic              ok;
        exp_addr = base_model + MEM_AW'({va[VA_W-1:12], 3'b000});
        exp_pfn  = pte[12 +: PA_W-12];
        ok       = pte[0];
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 busy after accept", 64'(busy), 1);
        check("R3 no read in index", 64'(mem_rd_req), 0);
        @(negedge clk);
        check("R3 read request", 64'(mem_rd_req), 1);
        check("R3 entry address", 64'(mem_rd_addr), 64'(exp_addr));
        for (int i = 0; i < delay; i++) begin
            if (intrude) begin
                req_valid = 1'b1; req_va = ~va;
                base_wr_en = 1'b1; base_wr_data = ~base_model;
            end
            @(negedge clk);
            req_valid = 1'b0; base_wr_en = 1'b0;
            check("R3 request held", 64'(mem_rd_req), 1);
            check("R3 address held", 64'(mem_rd_addr), 64'(exp_addr));
        end
        mem_rd_ack = 1'b1; mem_rd_data = pte;
        @(negedge clk);
        mem_rd_ack = 1'b0; mem_rd_data = '0;
        check("R9 single read", 64'(mem_rd_req), 0);
        check("R4 no early done", 64'({done, fault}), 0);
        @(negedge clk);
        check("R2 busy in report", 64'(busy), 1);
        if (ok) begin
            check("R4 done", 64'(done), 1);
            check("R5 no fault", 64'(fault), 0);
            check("R4 pa", 64'(pa_out), 64'({exp_pfn, va[11:0]}));
            check("R6 fill_valid", 64'(fill_valid), 1);
            check("R6 fill_vpn", 64'(fill_vpn), 64'(va[VA_W-1:12]));
            check("R6 fill_pfn", 64'(fill_pfn), 64'(exp_pfn));
        end else begin
            check("R5 fault", 64'(fault), 1);
            check("R5 no done", 64'(done), 0);
            check("R5 no fill", 64'(fill_valid), 0);
        end
        @(negedge clk);
        check("R2 pulse single", 64'({done, fault}), 0);
        check("R2 busy released", 64'(busy), 0);
        @(negedge clk);
        check("R7 no second walk busy", 64'(busy), 0);
        check("R7 no second read", 64'(mem_rd_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_base(40'h00_1000_0000);
        t_walk(32'h0000_1444, 64'h0000_0000_0000_5001, 0, 1'b0);
        t_walk(32'h1234_5ABC, 64'hFFF0_0ABC_DE12_3FFF, 3, 1'b0);
        t_walk(32'h0000_7010, 64'h0000_0000_0009_9000, 1, 1'b0);
        // R7 R8: second request and base write during the wait are dropped
        t_walk(32'h0040_2008, 64'h0000_0000_0077_7001, 3, 1'b1);
        t_walk(32'h0040_3008, 64'h0000_0000_0066_6001, 0, 1'b0);
        // R8: base write while idle is used by the next walk
        t_set_base(40'h80_0000_0000);
        t_walk(32'hFFFF_FFFF, 64'h0000_00FE_DCBA_9001, 2, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nvec++; nmis++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end
endmodule